// File: doc/BRIEF.md
# Shared Interrupt Router

This block steers a vector of pending shared interrupt sources onto the interrupt inputs of several virtual processors (VPs). Every source carries two configuration words: a pin word, made of a delivery-enable flag and an output pin number, and a VP bitmap naming the processor that receives it. Both words are loaded one at a time through a simple indexed write port. Each source normally targets a single VP through a one-hot bitmap.

For every VP, the router ORs together the pending, enabled sources that point at each pin. It presents the result in one of two forms, chosen by a mode input. In line mode, each VP gets a bus of core interrupt lines, and pin X lands on line X + 2. In vectored mode, each VP gets an encoded vector number equal to the winning pin + 1, and 0 means nothing is pending. All outputs are registered.

Top module: `irq_router`

## Requirements
- R1: After reset, every pin word has its enable clear, its pin number is 0 and every VP bitmap is all zero, so all line and vector outputs read 0.
- R2: A source whose pin-word enable flag is clear is never delivered to any VP, whatever its pending state and bitmap.
- R3: In line mode, a pending source that is enabled with pin X and has bit v set in its VP bitmap drives line X + 2 of VP v (bit v*(N_PIN+2)+X+2 of `irq_o`). Lines 0 and 1 of every VP are always 0.
- R4: A line stays high while any pending, enabled source mapped to that VP and pin remains. Removing one of two such sources keeps it high.
- R5: In vectored mode, the vector of VP v (`vec_o[v*VEC_W +: VEC_W]`) is the highest pin number among its pending, enabled sources plus 1, or 0 when there are none. In this mode all of `irq_o` is 0, and in line mode all of `vec_o` is 0.
- R6: Rewriting a source's VP bitmap moves its delivery to the new VP on the next output update. Its enable flag and pin number are unchanged.
- R7: An all-zero VP bitmap delivers the source nowhere. A bitmap with several bits set delivers it to every VP whose bit is set.
- R8: Outputs are registered. A change on `pend_i` or `vec_mode_i` appears on the outputs after the next rising clock edge, and a configuration write appears one edge after the write edge.
- R9: A pin number of N_PIN or above is treated as not delivered, even when the enable flag is set.
- R10: A write with `cfg_we_i`=1 and `cfg_vpmap_i`=0 loads the pin word of source `cfg_idx_i`: the enable flag comes from `cfg_data_i[PIN_W]` and the pin number from `cfg_data_i[PIN_W-1:0]`. With `cfg_vpmap_i`=1, the write loads the bitmap from `cfg_data_i[N_VP-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_SRC | Masked pending vector, one bit per source |
| vec_mode_i | input | 1 | 1 selects vectored output, 0 selects line output |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_vpmap_i | input | 1 | 0 writes the pin word, 1 writes the VP bitmap |
| cfg_idx_i | input | SRC_W | Source index of the write |
| cfg_data_i | input | CFG_W | Write data |
| irq_o | output | N_VP*(N_PIN+2) | Per-VP core interrupt lines |
| vec_o | output | N_VP*VEC_W | Per-VP encoded vector, 0 when none |

## Verification
The assertions assume that `cfg_idx_i` is below N_SRC whenever `cfg_we_i` is high. They also assume that `pend_i`, `vec_mode_i` and the write port are steady around the rising edge. The stimulus meets both assumptions: it changes every input only at the falling edge and uses only source indices that exist. It includes pin numbers above the valid range, so the disabled-pin handling is exercised while the indices stay legal.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic {
    CFG_PIN_WORD = 1'b0,
    CFG_VP_MAP   = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/rtr_cfg_regs.sv
module rtr_cfg_regs #(
  parameter int N_SRC = 16,
  parameter int N_VP  = 4,
  parameter int PIN_W = 3,
  parameter int SRC_W = 4,
  parameter int CFG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  rtr_pkg::cfg_kind_e     kind_i,
  input  logic [SRC_W-1:0]       idx_i,
  input  logic [CFG_W-1:0]       data_i,
  output logic [N_SRC-1:0]       pin_en_o,
  output logic [N_SRC*PIN_W-1:0] pin_num_o,
  output logic [N_SRC*N_VP-1:0]  vp_map_o
);
  import rtr_pkg::*;

  // Per-source write decode, brought out for the assertions.
  logic [N_SRC-1:0] pin_wr, map_wr;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign pin_wr[s] = we_i && (kind_i == CFG_PIN_WORD) && (idx_i == SRC_W'(s));
    assign map_wr[s] = we_i && (kind_i == CFG_VP_MAP)   && (idx_i == SRC_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_en_o[s]                  <= 1'b0;
        pin_num_o[s*PIN_W +: PIN_W]  <= '0;
        vp_map_o[s*N_VP +: N_VP]     <= '0;
      end else begin
        if (pin_wr[s]) begin
          pin_en_o[s]                 <= data_i[PIN_W];
          pin_num_o[s*PIN_W +: PIN_W] <= data_i[PIN_W-1:0];
        end
        if (map_wr[s]) begin
          vp_map_o[s*N_VP +: N_VP]    <= data_i[N_VP-1:0];
        end
      end
    end
  end

  p_map_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && kind_i == CFG_VP_MAP) |=>
      vp_map_o[$past(idx_i)*N_VP +: N_VP] == $past(data_i[N_VP-1:0]))
    else $error("VP bitmap write not taken");

  p_map_keeps_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && kind_i == CFG_VP_MAP) |=>
      (pin_en_o == $past(pin_en_o)) && (pin_num_o == $past(pin_num_o)))
    else $error("VP bitmap write disturbed pin word");

  p_onehot_decode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pin_wr | map_wr))
    else $error("write decode hit more than one source");
endmodule

// File: rtl/rtr_vp_lane.sv
module rtr_vp_lane #(
  parameter int N_SRC    = 16,
  parameter int N_PIN    = 6,
  parameter int PIN_W    = 3,
  parameter int VEC_W    = 3,
  parameter int LINE_OFS = 2,
  localparam int HWL     = N_PIN + LINE_OFS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vec_mode_i,
  input  logic [N_SRC-1:0]       live_i,
  input  logic [N_SRC-1:0]       sel_i,
  input  logic [N_SRC*PIN_W-1:0] pin_num_i,
  output logic [HWL-1:0]         irq_o,
  output logic [VEC_W-1:0]       vec_o
);
  // Highest requesting pin, encoded as pin + 1; 0 for none.
  function automatic logic [VEC_W-1:0] pin_vector(input logic [N_PIN-1:0] req);
    logic [VEC_W-1:0] v;
    v = '0;
    for (int p = 0; p < N_PIN; p++) begin
      if (req[p]) v = VEC_W'(p + 1);
    end
    return v;
  endfunction

  // Place pins above the lines reserved for software interrupts.
  function automatic logic [HWL-1:0] core_lines(input logic [N_PIN-1:0] req);
    return {req, {LINE_OFS{1'b0}}};
  endfunction

  logic [N_PIN-1:0] pin_req;
  logic [N_SRC-1:0] mine;

  assign mine = live_i & sel_i;

  always_comb begin
    pin_req = '0;
    for (int s = 0; s < N_SRC; s++) begin
      for (int p = 0; p < N_PIN; p++) begin
        if (mine[s] && (pin_num_i[s*PIN_W +: PIN_W] == PIN_W'(p)))
          pin_req[p] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= '0;
      vec_o <= '0;
    end else if (vec_mode_i) begin
      irq_o <= '0;
      vec_o <= pin_vector(pin_req);
    end else begin
      irq_o <= core_lines(pin_req);
      vec_o <= '0;
    end
  end

  p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vec_o) <= N_PIN)
    else $error("vector beyond pin range");

  p_vec_mode_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_mode_i |=> (irq_o == '0))
    else $error("lines active in vectored mode");

  p_idle_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mine == '0) |=> (irq_o == '0) && (vec_o == '0))
    else $error("output without a routed source");
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_SRC    = 16,
  parameter int N_VP     = 4,
  parameter int N_PIN    = 6,
  parameter int LINE_OFS = 2,
  localparam int PIN_W   = (N_PIN > 1) ? $clog2(N_PIN) : 1,
  localparam int SRC_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int VEC_W   = $clog2(N_PIN + 1),
  localparam int CFG_W   = (PIN_W + 1 > N_VP) ? PIN_W + 1 : N_VP,
  localparam int HWL     = N_PIN + LINE_OFS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      pend_i,
  input  logic                  vec_mode_i,
  input  logic                  cfg_we_i,
  input  logic                  cfg_vpmap_i,
  input  logic [SRC_W-1:0]      cfg_idx_i,
  input  logic [CFG_W-1:0]      cfg_data_i,
  output logic [N_VP*HWL-1:0]   irq_o,
  output logic [N_VP*VEC_W-1:0] vec_o
);
  import rtr_pkg::*;

  logic [N_SRC-1:0]       pin_en;
  logic [N_SRC*PIN_W-1:0] pin_num;
  logic [N_SRC*N_VP-1:0]  vp_map;
  logic [N_SRC-1:0]       live;
  cfg_kind_e              kind;

  assign kind = cfg_vpmap_i ? CFG_VP_MAP : CFG_PIN_WORD;

  rtr_cfg_regs #(
    .N_SRC(N_SRC), .N_VP(N_VP), .PIN_W(PIN_W), .SRC_W(SRC_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .kind_i(kind),
    .idx_i(cfg_idx_i), .data_i(cfg_data_i),
    .pin_en_o(pin_en), .pin_num_o(pin_num), .vp_map_o(vp_map)
  );

  // A source is live when pending, enabled and pointing at a real pin.
  for (genvar s = 0; s < N_SRC; s++) begin : g_live
    assign live[s] = pend_i[s] && pin_en[s] &&
                     (int'(pin_num[s*PIN_W +: PIN_W]) < N_PIN);
  end

  for (genvar v = 0; v < N_VP; v++) begin : g_vp
    logic [N_SRC-1:0] col;
    for (genvar s = 0; s < N_SRC; s++) begin : g_col
      assign col[s] = vp_map[s*N_VP + v];
    end

    rtr_vp_lane #(
      .N_SRC(N_SRC), .N_PIN(N_PIN), .PIN_W(PIN_W), .VEC_W(VEC_W),
      .LINE_OFS(LINE_OFS)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .vec_mode_i(vec_mode_i),
      .live_i(live), .sel_i(col), .pin_num_i(pin_num),
      .irq_o(irq_o[v*HWL +: HWL]), .vec_o(vec_o[v*VEC_W +: VEC_W])
    );
  end

  p_disabled_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en == '0) |=> (irq_o == '0) && (vec_o == '0))
    else $error("delivery with every source disabled");

  p_line_mode_novec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_mode_i |=> (vec_o == '0))
    else $error("vector active in line mode");
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int N_SRC = 16, N_VP = 4, N_PIN = 6;
  localparam int HWL = 8, VEC_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_SRC-1:0] pend = '0;
  logic vec_mode = 1'b0;
  logic we = 1'b0, vpmap = 1'b0;
  logic [3:0] idx = '0;
  logic [3:0] data = '0;
  logic [N_VP*HWL-1:0] irq;
  logic [N_VP*VEC_W-1:0] vec;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .vec_mode_i(vec_mode),
    .cfg_we_i(we), .cfg_vpmap_i(vpmap), .cfg_idx_i(idx), .cfg_data_i(data),
    .irq_o(irq), .vec_o(vec)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pin word: data = {enable, pin[2:0]} (R10)
  task automatic wr_pin(input int s, input bit en, input int pin);
    we = 1; vpmap = 0; idx = 4'(s); data = {en, 3'(pin)};
    tick(); we = 0;
  endtask

  task automatic wr_map(input int s, input logic [3:0] m);
    we = 1; vpmap = 1; idx = 4'(s); data = m;
    tick(); we = 0;
  endtask

  function automatic logic [31:0] line(input int v, input int pin);
    return 32'(1) << (v*HWL + pin + 2);
  endfunction

  task automatic t_reset();
    chk("R1 lines", 64'(irq), 0);
    chk("R1 vec", 64'(vec), 0);
  endtask

  task automatic t_basic();
    wr_pin(3, 1, 2); wr_map(3, 4'b0010);
    pend[3] = 1;
    chk("R8 before edge", 64'(irq), 0);
    tick();
    chk("R3 VP1 pin2", 64'(irq), 64'(line(1, 2)));
    chk("R3 low lines", 64'(irq & 32'h03030303), 0);
  endtask

  task automatic t_or();
    wr_pin(5, 1, 2); wr_map(5, 4'b0010);
    pend[5] = 1; tick();
    chk("R4 both", 64'(irq), 64'(line(1, 2)));
    pend[3] = 0; tick();
    chk("R4 one left", 64'(irq), 64'(line(1, 2)));
    pend[5] = 0; tick();
    chk("R4 none", 64'(irq), 0);
  endtask

  task automatic t_disabled();
    wr_pin(7, 0, 1); wr_map(7, 4'b0001);
    pend[7] = 1; tick();
    chk("R2 disabled", 64'(irq), 0);
    wr_pin(8, 1, 7); wr_map(8, 4'b0001);
    pend[8] = 1; tick();
    chk("R9 pin out of range", 64'(irq), 0);
    wr_pin(8, 1, 6); tick();
    chk("R9 pin equal N_PIN", 64'(irq), 0);
    pend[7] = 0; pend[8] = 0;
  endtask

  task automatic t_maps();
    wr_pin(9, 1, 0);
    pend[9] = 1; tick();
    chk("R7 zero map", 64'(irq), 0);
    wr_map(9, 4'b1010); tick();
    chk("R7 multi map", 64'(irq), 64'(line(1, 0) | line(3, 0)));
    pend[9] = 0; tick();
  endtask

  task automatic t_move();
    pend[3] = 1; tick();
    chk("R6 before", 64'(irq), 64'(line(1, 2)));
    wr_map(3, 4'b0100);
    chk("R8 write latency", 64'(irq), 64'(line(1, 2)));
    tick();
    chk("R6 moved", 64'(irq), 64'(line(2, 2)));
  endtask

  task automatic t_vector();
    wr_pin(10, 1, 5); wr_map(10, 4'b0100);
    pend[9] = 1; pend[10] = 1; vec_mode = 1;
    tick();
    chk("R5 vec", 64'(vec), 64'({3'd1, 3'd6, 3'd1, 3'd0}));
    chk("R5 lines quiet", 64'(irq), 0);
    pend[10] = 0; tick();
    chk("R5 lower pin", 64'(vec), 64'({3'd1, 3'd3, 3'd1, 3'd0}));
    pend = '0; tick();
    chk("R5 empty", 64'(vec), 0);
    vec_mode = 0; pend[3] = 1; tick();
    chk("R5 line mode vec", 64'(vec), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_basic();
    t_or();
    t_disabled();
    t_maps();
    t_move();
    t_vector();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule